// File: doc/BRIEF.md
# Paged Control Register Bank

This block is the host-visible control store of an eight-channel line interface. A host talks to it over a plain synchronous bus with a five-bit address, a byte of write data, write and read strobes, and a registered read-data byte. The 32-location address space is shared by two pages. The primary page holds the ordinary control bytes. The expanded page holds eight per-channel enable masks and a run of zero-reset test bytes. Every stored control bit leaves the block as a parallel output, so the datapath never needs to decode bus cycles.

Location 0x1F is the page pointer on both pages. Writing 0xAA to it from the primary page moves all later accesses to the expanded page. Writing 0x00 to it from the expanded page moves them back. Any other value changes nothing. A write of any value to primary location 0x0A is a software reset: in one clock cycle, every register on both pages returns to its default.

Top module: `paged_regbank`

## Requirements
- R1: After power-on reset, the primary page is selected and `exp_page` is 0. Every primary byte is 0x00 except location 0x0A, which is 0xFF. `chan_cfg` is all zero, `ja_wide` is 0, and `rdata` is 0x00.
- R2: Primary locations 0x00 to 0x15 are read/write bytes. Byte k appears at `prim_regs[8k+7:8k]` in the cycle after its write. A read (`rd_en` high at a clock edge) puts the addressed byte on `rdata` after that edge, and `rdata` holds while `rd_en` is low.
- R3: A write of 0xAA to 0x1F while on the primary page sets `exp_page` to 1 from the next cycle. While on the expanded page, a read of 0x1F returns 0xAA.
- R4: A write of 0x00 to 0x1F while on the expanded page clears `exp_page` from the next cycle. While on the primary page, a read of 0x1F returns 0x00.
- R5: A write to 0x1F of any value other than the one that leaves the current page leaves `exp_page` unchanged. This includes 0x00 written on the primary page and 0xAA written on the expanded page.
- R6: On the primary page, locations 0x16 to 0x1E read 0x00, and writes to them change no register.
- R7: On the expanded page, locations 0x00 to 0x07 are channel masks, and bit n of each mask is channel n. Mask k drives `chan_cfg[8k+7:8k]`. In order of k, the masks are: single-rail mode, line-code select, clock-recovery enable, receiver power-down, transmitter power-down, zero-run detect enable, code-violation detect enable, and equalizer enable.
- R8: On the expanded page, locations 0x08 to 0x1E are read/write test bytes that reset to 0x00. This includes location 0x0A, which is not a software reset on this page.
- R9: A write of any value to primary location 0x0A returns every register on both pages to its R1 default in the next cycle, and leaves the primary page selected.
- R10: `ja_wide` equals bit 2 of primary location 0x0F. A value of 0 selects the lower jitter-attenuator corner and 1 selects the higher.
- R11: A write on one page never changes a register on the other page at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one byte per asserted cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered, held between reads |
| exp_page | output | 1 | 1 while the expanded page is selected |
| prim_regs | output | 176 | Primary bytes 0x00 to 0x15, byte k at bits 8k+7:8k |
| chan_cfg | output | 64 | Channel masks, mask k at bits 8k+7:8k |
| ja_wide | output | 1 | Jitter-attenuator bandwidth select |

## Verification
The properties assume a single-port host. At most one of a write and a read matters to the checked outcome in any cycle. `addr` and `wdata` are taken as meaningful only while a strobe is high, and the read-hold property assumes nothing else drives `rdata`. The stimulus issues each access as a one-cycle strobe and separates it from the next by an idle cycle. It changes address and data only at falling edges, and it never asserts both strobes at once. Page changes are always made through complete pointer writes, so the properties on page transitions see one clean write per access.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

   typedef enum logic {
      PG_PRIMARY  = 1'b0,
      PG_EXPANDED = 1'b1
   } page_e;

endpackage

// File: rtl/pgreg_pager.sv
module pgreg_pager
   import pgreg_pkg::*;
#(
   parameter int unsigned     DATA_W   = 8,
   parameter int unsigned     ADDR_W   = 5,
   parameter int unsigned     PTR_ADDR = 31,
   parameter logic [DATA_W-1:0] KEY_EXP = 'hAA,
   parameter logic [DATA_W-1:0] KEY_PRI = 'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output page_e             page_o,
   output logic [DATA_W-1:0] ptr_rd
);

   page_e page_q;
   logic  ptr_wr;

   assign ptr_wr = wr_en && (addr == ADDR_W'(PTR_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= PG_PRIMARY;
      end else if (ptr_wr) begin
         unique case (page_q)
            PG_PRIMARY:  if (wdata == KEY_EXP) page_q <= PG_EXPANDED;
            PG_EXPANDED: if (wdata == KEY_PRI) page_q <= PG_PRIMARY;
            default:     page_q <= PG_PRIMARY;
         endcase
      end
   end

   assign page_o = page_q;
   assign ptr_rd = (page_q == PG_EXPANDED) ? KEY_EXP : KEY_PRI;

endmodule

// File: rtl/pgreg_bank.sv
module pgreg_bank #(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       ADDR_W      = 5,
   parameter int unsigned       N_REG       = 22,
   parameter int                SPECIAL_IDX = -1,
   parameter logic [DATA_W-1:0] SPECIAL_VAL = '0,
   localparam int unsigned      BANK_W      = N_REG * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              sel,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [BANK_W-1:0] regs_o
);

   if (N_REG < 1 || N_REG > (1 << ADDR_W)) begin : g_bad_depth
      $error("pgreg_bank: N_REG out of range for ADDR_W");
   end

   for (genvar g = 0; g < N_REG; g++) begin : g_reg
      localparam logic [DATA_W-1:0] DEF_VAL = (g == SPECIAL_IDX) ? SPECIAL_VAL : '0;
      logic [DATA_W-1:0] byte_q;
      logic              hit;

      assign hit = sel && wr_en && (addr == ADDR_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= DEF_VAL;
         end else if (clr) begin
            byte_q <= DEF_VAL;
         end else if (hit) begin
            byte_q <= wdata;
         end
      end

      assign regs_o[g*DATA_W +: DATA_W] = byte_q;
   end

endmodule

// File: rtl/pgreg_rdsel.sv
module pgreg_rdsel #(
   parameter int unsigned  DATA_W = 8,
   parameter int unsigned  ADDR_W = 5,
   parameter int unsigned  N_REG  = 22,
   localparam int unsigned BANK_W = N_REG * DATA_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BANK_W-1:0] regs,
   output logic [DATA_W-1:0] rd_o
);

   always_comb begin
      rd_o = '0;
      for (int i = 0; i < int'(N_REG); i++) begin
         if (addr == ADDR_W'(i)) rd_o = regs[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/paged_regbank.sv
module paged_regbank
   import pgreg_pkg::*;
#(
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       ADDR_W    = 5,
   parameter int unsigned       N_CHAN    = 8,
   parameter int unsigned       N_MASK    = 8,
   parameter int unsigned       PRIM_N    = 22,
   parameter int unsigned       PTR_ADDR  = 31,
   parameter int unsigned       RST_ADDR  = 10,
   parameter int unsigned       GCTL_ADDR = 15,
   parameter int unsigned       JA_BIT    = 2,
   parameter logic [DATA_W-1:0] KEY_EXP   = 'hAA,
   parameter logic [DATA_W-1:0] KEY_PRI   = 'h00,
   parameter logic [DATA_W-1:0] RST_VAL   = 'hFF,
   parameter bit                RDATA_REG = 1'b1,
   localparam int unsigned      EXP_N     = PTR_ADDR,
   localparam int unsigned      PRIM_W    = PRIM_N * DATA_W,
   localparam int unsigned      EXP_W     = EXP_N * DATA_W,
   localparam int unsigned      CFG_W     = N_MASK * N_CHAN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   output logic              exp_page,
   output logic [PRIM_W-1:0] prim_regs,
   output logic [CFG_W-1:0]  chan_cfg,
   output logic              ja_wide
);

   // elaboration-time parameter checks
   if (PTR_ADDR >= (1 << ADDR_W)) begin : g_bad_ptr
      $error("paged_regbank: PTR_ADDR does not fit ADDR_W");
   end
   if (PRIM_N > PTR_ADDR) begin : g_bad_prim
      $error("paged_regbank: primary bank overlaps the pointer");
   end
   if (RST_ADDR >= PRIM_N || GCTL_ADDR >= PRIM_N) begin : g_bad_ctl
      $error("paged_regbank: reset or global control outside primary bank");
   end
   if (JA_BIT >= DATA_W) begin : g_bad_bit
      $error("paged_regbank: JA_BIT outside a byte");
   end
   if (N_CHAN != DATA_W) begin : g_bad_chan
      $error("paged_regbank: one mask bit per channel requires N_CHAN == DATA_W");
   end
   if (N_MASK > EXP_N) begin : g_bad_mask
      $error("paged_regbank: too many masks for the expanded page");
   end
   if (KEY_EXP == KEY_PRI) begin : g_bad_key
      $error("paged_regbank: page keys must differ");
   end

   page_e             page;
   logic [DATA_W-1:0] ptr_rd;
   logic              on_prim;
   logic              on_exp;
   logic              soft_rst;
   logic [EXP_W-1:0]  exp_regs;
   logic [DATA_W-1:0] prim_rd;
   logic [DATA_W-1:0] exp_rd;
   logic [DATA_W-1:0] rd_val;

   pgreg_pager #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .PTR_ADDR(PTR_ADDR),
      .KEY_EXP (KEY_EXP),
      .KEY_PRI (KEY_PRI)
   ) u_pager (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .page_o(page),
      .ptr_rd(ptr_rd)
   );

   assign on_prim  = (page == PG_PRIMARY);
   assign on_exp   = (page == PG_EXPANDED);
   assign soft_rst = wr_en && on_prim && (addr == ADDR_W'(RST_ADDR));

   pgreg_bank #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .N_REG      (PRIM_N),
      .SPECIAL_IDX(int'(RST_ADDR)),
      .SPECIAL_VAL(RST_VAL)
   ) u_prim (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst),
      .sel   (on_prim),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .regs_o(prim_regs)
   );

   pgreg_bank #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .N_REG      (EXP_N),
      .SPECIAL_IDX(-1),
      .SPECIAL_VAL('0)
   ) u_exp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst),
      .sel   (on_exp),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .regs_o(exp_regs)
   );

   pgreg_rdsel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_REG(PRIM_N)) u_rd_prim (
      .addr(addr),
      .regs(prim_regs),
      .rd_o(prim_rd)
   );

   pgreg_rdsel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_REG(EXP_N)) u_rd_exp (
      .addr(addr),
      .regs(exp_regs),
      .rd_o(exp_rd)
   );

   always_comb begin
      if (addr == ADDR_W'(PTR_ADDR)) rd_val = ptr_rd;
      else if (on_exp)               rd_val = exp_rd;
      else                           rd_val = prim_rd;
   end

   if (RDATA_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata <= '0;
         else if (rd_en) rdata <= rd_val;
      end
   end else begin : g_rd_comb
      assign rdata = rd_en ? rd_val : '0;
   end

   assign exp_page = on_exp;
   assign chan_cfg = exp_regs[CFG_W-1:0];
   assign ja_wide  = prim_regs[GCTL_ADDR*DATA_W + JA_BIT];

endmodule

// File: rtl/pgreg_checker.sv
module pgreg_checker #(
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       ADDR_W    = 5,
   parameter int unsigned       PRIM_N    = 22,
   parameter int unsigned       CFG_W     = 64,
   parameter int unsigned       PTR_ADDR  = 31,
   parameter int unsigned       RST_ADDR  = 10,
   parameter logic [DATA_W-1:0] KEY_EXP   = 'hAA,
   parameter logic [DATA_W-1:0] KEY_PRI   = 'h00,
   parameter logic [DATA_W-1:0] RST_VAL   = 'hFF,
   parameter bit                RDATA_REG = 1'b1,
   localparam int unsigned      PRIM_W    = PRIM_N * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rdata,
   input logic              exp_page,
   input logic [PRIM_W-1:0] prim_regs,
   input logic [CFG_W-1:0]  chan_cfg
);

   localparam logic [PRIM_W-1:0] PRIM_DEF = PRIM_W'(RST_VAL) << (RST_ADDR * DATA_W);

   logic ptr_wr;
   logic rsvd_acc;
   assign ptr_wr   = wr_en && (addr == ADDR_W'(PTR_ADDR));
   assign rsvd_acc = !exp_page && (addr >= ADDR_W'(PRIM_N)) && (addr < ADDR_W'(PTR_ADDR));

   a_r3_enter_expanded: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr && !exp_page && wdata == KEY_EXP) |=> exp_page);

   a_r4_leave_expanded: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr && exp_page && wdata == KEY_PRI) |=> !exp_page);

   a_r5_other_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr && (exp_page ? (wdata != KEY_PRI) : (wdata != KEY_EXP))) |=> $stable(exp_page));

   a_r5_no_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_wr |=> $stable(exp_page));

   a_r6_rsvd_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rsvd_acc) |=> ($stable(prim_regs) && $stable(chan_cfg)));

   a_r6_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (RDATA_REG && rd_en && !wr_en && rsvd_acc) |=> (rdata == '0));

   a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (RDATA_REG && !rd_en) |=> $stable(rdata));

   a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !exp_page && addr == ADDR_W'(RST_ADDR))
      |=> (prim_regs == PRIM_DEF && chan_cfg == '0 && !exp_page));

   a_r11_exp_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && exp_page) |=> $stable(prim_regs));

endmodule

bind paged_regbank pgreg_checker #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .PRIM_N   (PRIM_N),
   .CFG_W    (CFG_W),
   .PTR_ADDR (PTR_ADDR),
   .RST_ADDR (RST_ADDR),
   .KEY_EXP  (KEY_EXP),
   .KEY_PRI  (KEY_PRI),
   .RST_VAL  (RST_VAL),
   .RDATA_REG(RDATA_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .wdata    (wdata),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .rdata    (rdata),
   .exp_page (exp_page),
   .prim_regs(prim_regs),
   .chan_cfg (chan_cfg)
);

// File: tb/paged_regbank_test.sv
module paged_regbank_test;

   localparam int PRIM_W = 22 * 8;
   localparam int CFG_W  = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [4:0]        addr = '0;
   logic [7:0]        wdata = '0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [7:0]        rdata;
   logic              exp_page;
   logic [PRIM_W-1:0] prim_regs;
   logic [CFG_W-1:0]  chan_cfg;
   logic              ja_wide;

   always #10 clk = ~clk;

   paged_regbank uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .wdata    (wdata),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .rdata    (rdata),
      .exp_page (exp_page),
      .prim_regs(prim_regs),
      .chan_cfg (chan_cfg),
      .ja_wide  (ja_wide)
   );

   int         n_chk = 0;
   int         n_fail = 0;
   logic [7:0] sb_val[$];
   string      sb_tag[$];
   logic       rd_seen = 1'b0;
   bit         done = 1'b0;

   task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, logic [7:0] e, string tag);
      sb_val.push_back(e);
      sb_tag.push_back(tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   function automatic logic [7:0] pbyte(int k);
      return prim_regs[k*8 +: 8];
   endfunction

   function automatic logic [7:0] mbyte(int k);
      return chan_cfg[k*8 +: 8];
   endfunction

   // monitor: compares each read result against the scoreboard
   always @(posedge clk) rd_seen <= rd_en;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb_val.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0h expected none", rdata);
         end else begin
            check(sb_tag.pop_front(), 256'(rdata), 256'(sb_val.pop_front()));
         end
      end
   end

   localparam logic [PRIM_W-1:0] PRIM_DEF = PRIM_W'(8'hFF) << (10 * 8);

   initial begin
      logic [PRIM_W-1:0] snap;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 exp_page", 256'(exp_page), 256'(0));
      check("R1 prim_regs", 256'(prim_regs), 256'(PRIM_DEF));
      check("R1 chan_cfg", 256'(chan_cfg), 256'(0));
      check("R1 ja_wide", 256'(ja_wide), 256'(0));
      check("R1 rdata", 256'(rdata), 256'(0));
      rst_n = 1'b1;
      rd(5'h0A, 8'hFF, "R1 read reset reg");
      rd(5'h00, 8'h00, "R1 read 0x00");
      rd(5'h1F, 8'h00, "R4 pointer reads 00 on primary");

      // R2 primary read/write
      wr(5'h03, 8'h5A);
      wr(5'h15, 8'hC3);
      check("R2 prim byte 3", 256'(pbyte(3)), 256'(8'h5A));
      check("R2 prim byte 0x15", 256'(pbyte(21)), 256'(8'hC3));
      rd(5'h03, 8'h5A, "R2 read 0x03");
      rd(5'h15, 8'hC3, "R2 read 0x15");
      @(negedge clk);
      addr = 5'h15;
      repeat (2) @(negedge clk);
      check("R2 rdata held", 256'(rdata), 256'(8'hC3));

      // R10 jitter-attenuator bandwidth bit
      wr(5'h0F, 8'h04);
      check("R10 ja_wide set", 256'(ja_wide), 256'(1));
      wr(5'h0F, 8'hFB);
      check("R10 ja_wide clear", 256'(ja_wide), 256'(0));

      // R6 reserved addresses
      snap = prim_regs;
      wr(5'h16, 8'h77);
      wr(5'h1E, 8'h12);
      check("R6 reserved writes ignored", 256'(prim_regs), 256'(snap));
      check("R6 reserved writes no mask", 256'(chan_cfg), 256'(0));
      rd(5'h16, 8'h00, "R6 read 0x16");
      rd(5'h1E, 8'h00, "R6 read 0x1E");

      // R5 non-leaving values on primary
      wr(5'h1F, 8'h00);
      check("R5 00 on primary", 256'(exp_page), 256'(0));
      wr(5'h1F, 8'h55);
      check("R5 55 on primary", 256'(exp_page), 256'(0));

      // R3 enter expanded page
      wr(5'h1F, 8'hAA);
      check("R3 enter expanded", 256'(exp_page), 256'(1));
      rd(5'h1F, 8'hAA, "R3 pointer reads AA");

      // R7 channel masks
      wr(5'h00, 8'h81);
      wr(5'h07, 8'h3C);
      wr(5'h04, 8'h01);
      check("R7 single-rail mask", 256'(mbyte(0)), 256'(8'h81));
      check("R7 equalizer mask", 256'(mbyte(7)), 256'(8'h3C));
      check("R7 tx power-down ch0", 256'(chan_cfg[4*8 + 0]), 256'(1));
      check("R7 tx power-down ch1", 256'(chan_cfg[4*8 + 1]), 256'(0));
      rd(5'h07, 8'h3C, "R7 read mask 7");

      // R11 page isolation
      rd(5'h03, 8'h00, "R11 expanded 0x03 distinct");
      check("R11 primary 0x03 kept", 256'(pbyte(3)), 256'(8'h5A));

      // R8 test registers, including 0x0A on this page
      wr(5'h08, 8'h11);
      wr(5'h1E, 8'hEE);
      wr(5'h0A, 8'h66);
      check("R8 0x0A is no reset here", 256'(pbyte(3)), 256'(8'h5A));
      check("R8 page kept", 256'(exp_page), 256'(1));
      rd(5'h08, 8'h11, "R8 read 0x08");
      rd(5'h1E, 8'hEE, "R8 read 0x1E");
      rd(5'h0A, 8'h66, "R8 read 0x0A");

      // R5 non-leaving values on expanded
      wr(5'h1F, 8'hAA);
      check("R5 AA on expanded", 256'(exp_page), 256'(1));
      wr(5'h1F, 8'h01);
      check("R5 01 on expanded", 256'(exp_page), 256'(1));

      // R4 leave expanded page
      wr(5'h1F, 8'h00);
      check("R4 leave expanded", 256'(exp_page), 256'(0));
      rd(5'h1F, 8'h00, "R4 pointer reads 00");
      rd(5'h03, 8'h5A, "R11 primary 0x03 after return");

      // R9 software reset
      wr(5'h0A, 8'h00);
      check("R9 prim defaults", 256'(prim_regs), 256'(PRIM_DEF));
      check("R9 masks cleared", 256'(chan_cfg), 256'(0));
      check("R9 primary page", 256'(exp_page), 256'(0));
      rd(5'h0A, 8'hFF, "R9 reset reg reads FF");
      wr(5'h1F, 8'hAA);
      rd(5'h08, 8'h00, "R9 test reg 0x08 cleared");
      rd(5'h0A, 8'h00, "R9 test reg 0x0A cleared");
      wr(5'h1F, 8'h00);

      repeat (3) @(negedge clk);
      if (sb_val.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb_val.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule